// File: doc/BRIEF.md
# DMA Request Word Decoder

This block takes 64-bit request words from an external master over a valid/ready handshake. It splits each word into its fields: unit size, direction, channel, request mode, unit count and address. A word for channels 1 to 3 is reduced to a single-cycle strobe on that channel's line. A word for channel 0 starts a transfer.

During a channel-0 transfer the block latches the attributes and holds a 24-bit count of remaining units. It then raises unit requests toward a bus engine. In edge-sense burst mode a unit completes on every cycle. In level-sense burst mode and cycle-steal mode, each unit waits for an acknowledge from the engine. In cycle-steal mode the request also drops for one cycle after each acknowledged unit.

Two size codes act as commands on channel 0. One clears the request queue. The other ends the active transfer.

Top module: `dma_req_decoder`

## Requirements
- R1: Word fields are: size code in bits 63:61, direction in bit 60 (1 = write), channel in bits 59:58, mode in bits 57:56, count in bits 55:48 and address in bits 31:0. Bits 47:32 are ignored. When a channel-0 transfer starts, the latched address, direction and size code appear on `unit_addr_o`, `unit_write_o` and `unit_size_o` from the next cycle.
- R2: A word accepted with channel 1, 2 or 3 produces a one-cycle pulse on `ch_req_o[ch-1]` in the cycle after acceptance. All of its other fields are ignored: it raises no error and starts nothing.
- R3: A channel-0 word with size code 101 pulses `err_o` in the next cycle and starts no transfer.
- R4: A channel-0 word with mode 00 and size code 000 to 100 is accepted. It starts nothing, whatever its count.
- R5: A channel-0 start with mode 01, 10 or 11 sets `active_o` from the next cycle and completes exactly `count` units. One cycle after the last unit, `done_o` pulses and `active_o` falls. A count of 0 means 2^24 units.
- R6: Mode 01 (edge-sense burst): `unit_req_o` stays high for the whole transfer, and every active cycle completes one unit with no acknowledge.
- R7: Mode 10 (level-sense burst): a unit completes only when `unit_req_o` and `unit_ack_i` are both high. Until then the request is held.
- R8: Mode 11 (cycle steal): a unit completes only on acknowledge, and `unit_req_o` is low in the cycle after each completed unit.
- R9: A channel-0 word with size code 111 accepted during a transfer stops it: `done_o` pulses and `active_o` is low in the next cycle. Accepted while idle, it has no effect.
- R10: A channel-0 word with size code 110 returns the block to idle in the next cycle with no `done_o` pulse, dropping any pending unit.
- R11: `req_ready_o` is high while idle. During a transfer it is high only for channel-0 words with size code 110 or 111, so all other words are held off.
- R12: After reset, `req_ready_o` is high and every other output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request word valid |
| req_ready_o | output | 1 | Request word can be accepted |
| req_word_i | input | 64 | Request word |
| ch_req_o | output | 3 | Channel 1..3 request strobes, bit ch-1 |
| err_o | output | 1 | Illegal size code pulse |
| active_o | output | 1 | Channel-0 transfer in progress |
| unit_req_o | output | 1 | Unit transfer request |
| unit_ack_i | input | 1 | Unit acknowledge (modes 10 and 11) |
| unit_size_o | output | 3 | Latched size code |
| unit_write_o | output | 1 | Latched direction, 1 = write |
| unit_addr_o | output | 32 | Latched source or destination address |
| done_o | output | 1 | Transfer finished pulse |

## Verification
The assertions assume that `unit_ack_i` has meaning only while `unit_req_o` is high. They also assume that the master keeps `req_valid_i` low after a word is taken, unless it presents another word. The stimulus drives the acknowledge from a random bit each cycle. It presents every word for exactly one cycle, except where the test of R11 deliberately holds a word off. Random transfers use counts up to 40 so that each run stays short. The zero-count case is instead checked by running past 255 units and then ending the transfer with a command.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  localparam int WORD_W = 64;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 24;
  localparam int NCH    = 4;
  localparam int CH_W   = $clog2(NCH);
  localparam int RAW_CNT_W = 8;

  localparam logic [2:0] SZ_ILLEGAL = 3'b101;
  localparam logic [2:0] SZ_QCLR    = 3'b110;
  localparam logic [2:0] SZ_END     = 3'b111;

  typedef enum logic [1:0] {
    MODE_HS    = 2'b00,
    MODE_EDGE  = 2'b01,
    MODE_LEVEL = 2'b10,
    MODE_STEAL = 2'b11
  } xfer_mode_e;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_START, CMD_CHAN, CMD_ERR, CMD_QCLR, CMD_END
  } cmd_e;

  typedef struct packed {
    logic [2:0]           size;
    logic                 write;
    logic [CH_W-1:0]      chan;
    xfer_mode_e           mode;
    logic [RAW_CNT_W-1:0] count;
    logic [ADDR_W-1:0]    addr;
  } req_fields_t;
endpackage

// File: rtl/dmaw_decode.sv
module dmaw_decode
  import dmaw_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output req_fields_t       fields_o,
  output cmd_e              cmd_o
);
  always_comb begin
    fields_o.size  = word_i[63:61];
    fields_o.write = word_i[60];
    fields_o.chan  = word_i[59:58];
    fields_o.mode  = xfer_mode_e'(word_i[57:56]);
    fields_o.count = word_i[55:48];
    fields_o.addr  = word_i[ADDR_W-1:0];
  end

  always_comb begin
    if (fields_o.chan != '0)             cmd_o = CMD_CHAN;
    else if (fields_o.size == SZ_ILLEGAL) cmd_o = CMD_ERR;
    else if (fields_o.size == SZ_QCLR)    cmd_o = CMD_QCLR;
    else if (fields_o.size == SZ_END)     cmd_o = CMD_END;
    else if (fields_o.mode == MODE_HS)    cmd_o = CMD_NONE;
    else                                  cmd_o = CMD_START;
  end
endmodule

// File: rtl/dmaw_chan_fwd.sv
module dmaw_chan_fwd
  import dmaw_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_i,
  input  logic [CH_W-1:0] chan_i,
  output logic [NCH-2:0]  ch_req_o
);
  for (genvar g = 1; g < NCH; g++) begin : g_strobe
    logic strobe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) strobe_q <= 1'b0;
      else         strobe_q <= fire_i && (chan_i == CH_W'(g));
    end
    assign ch_req_o[g-1] = strobe_q;
  end

  // R2: at most one channel strobe at a time
  p_onehot_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_req_o));
endmodule

// File: rtl/dmaw_seq.sv
module dmaw_seq
  import dmaw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              qclr_i,
  input  logic              end_i,
  input  req_fields_t       fields_i,
  input  logic              unit_ack_i,
  output logic              active_o,
  output logic              unit_req_o,
  output logic [2:0]        unit_size_o,
  output logic              unit_write_o,
  output logic [ADDR_W-1:0] unit_addr_o,
  output logic              done_o
);
  logic              active_q, gap_q, done_q, write_q;
  xfer_mode_e        mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0]        size_q;
  logic [ADDR_W-1:0] addr_q;
  logic              unit_fire, last_unit;

  assign unit_req_o = active_q && !gap_q;
  assign unit_fire  = unit_req_o && (mode_q == MODE_EDGE || unit_ack_i);
  // zero count wraps through all ones: 2^CNT_W units
  assign last_unit  = unit_fire && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      gap_q    <= 1'b0;
      done_q   <= 1'b0;
      write_q  <= 1'b0;
      mode_q   <= MODE_HS;
      cnt_q    <= '0;
      size_q   <= '0;
      addr_q   <= '0;
    end else begin
      done_q <= 1'b0;
      gap_q  <= unit_fire && (mode_q == MODE_STEAL) && !last_unit;
      if (qclr_i) begin
        active_q <= 1'b0;
        gap_q    <= 1'b0;
      end else if (end_i) begin
        done_q   <= active_q;
        active_q <= 1'b0;
        gap_q    <= 1'b0;
      end else if (start_i) begin
        active_q <= 1'b1;
        gap_q    <= 1'b0;
        mode_q   <= fields_i.mode;
        cnt_q    <= CNT_W'(fields_i.count);
        size_q   <= fields_i.size;
        write_q  <= fields_i.write;
        addr_q   <= fields_i.addr;
      end else if (unit_fire) begin
        cnt_q <= cnt_q - 1'b1;
        if (last_unit) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  assign active_o     = active_q;
  assign done_o       = done_q;
  assign unit_size_o  = size_q;
  assign unit_write_o = write_q;
  assign unit_addr_o  = addr_q;

  p_hold_until_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_EDGE && unit_req_o && !unit_ack_i && !qclr_i && !end_i)
    |=> unit_req_o);

  p_steal_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_fire && mode_q == MODE_STEAL) |=> !unit_req_o);

  p_done_after_active_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(active_q) && !active_o));

  p_qclr_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qclr_i |=> (!active_o && !done_o && !unit_req_o));
endmodule

// File: rtl/dma_req_decoder.sv
module dma_req_decoder
  import dmaw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [WORD_W-1:0] req_word_i,
  output logic [NCH-2:0]    ch_req_o,
  output logic              err_o,
  output logic              active_o,
  output logic              unit_req_o,
  input  logic              unit_ack_i,
  output logic [2:0]        unit_size_o,
  output logic              unit_write_o,
  output logic [ADDR_W-1:0] unit_addr_o,
  output logic              done_o
);
  req_fields_t fields;
  cmd_e        cmd;
  logic        accept, err_q, is_ctrl;

  dmaw_decode u_decode (
    .word_i   (req_word_i),
    .fields_o (fields),
    .cmd_o    (cmd)
  );

  assign is_ctrl     = (cmd == CMD_QCLR) || (cmd == CMD_END);
  assign req_ready_o = !active_o || is_ctrl;
  assign accept      = req_valid_i && req_ready_o;

  dmaw_chan_fwd u_chan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (accept && cmd == CMD_CHAN),
    .chan_i   (fields.chan),
    .ch_req_o (ch_req_o)
  );

  dmaw_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (accept && cmd == CMD_START),
    .qclr_i       (accept && cmd == CMD_QCLR),
    .end_i        (accept && cmd == CMD_END),
    .fields_i     (fields),
    .unit_ack_i   (unit_ack_i),
    .active_o     (active_o),
    .unit_req_o   (unit_req_o),
    .unit_size_o  (unit_size_o),
    .unit_write_o (unit_write_o),
    .unit_addr_o  (unit_addr_o),
    .done_o       (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= accept && cmd == CMD_ERR;
  end
  assign err_o = err_q;

  p_err_no_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cmd == CMD_ERR && !active_o) |=> (err_o && !active_o));

  p_hold_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o) |=> (ch_req_o == '0 && !err_o));
endmodule

// File: tb/dma_req_decoder_test.sv
module dma_req_decoder_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [63:0] req_word_i = '0;
  logic [2:0]  ch_req_o;
  logic        err_o, active_o, unit_req_o, unit_write_o, done_o;
  logic        unit_ack_i = 1'b0;
  logic [2:0]  unit_size_o;
  logic [31:0] unit_addr_o;
  int checks = 0;
  int fails  = 0;

  always #4 clk_i = ~clk_i;

  dma_req_decoder uut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] mk(input logic [2:0] sz, input logic wr, input logic [1:0] ch,
                                     input logic [1:0] md, input logic [7:0] cnt, input logic [31:0] a);
    logic [15:0] rsv = 16'($urandom);
    return {sz, wr, ch, md, cnt, rsv, a};
  endfunction

  // starts and ends at a negedge; word is presented for one edge
  task automatic put(input logic [63:0] w);
    req_valid_i = 1'b1;
    req_word_i  = w;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic run_xfer(input logic [1:0] md, input logic [7:0] cnt, input logic [2:0] sz,
                          input logic wr, input logic [31:0] a);
    int  units = 0;
    int  iters = 0;
    bit  prev_fire = 0, prev_req = 0, seen_done = 0;
    put(mk(sz, wr, 2'd0, md, cnt, a));
    chk(active_o == 1'b1, "R5 active after start", active_o, 1);
    chk(unit_addr_o == a && unit_write_o == wr && unit_size_o == sz, "R1 latched fields",
        {unit_size_o, unit_write_o, unit_addr_o}, {sz, wr, a});
    while (iters < 2000) begin
      if (done_o) begin seen_done = 1; break; end
      if (md == 2'b01) chk(unit_req_o, "R6 continuous request", unit_req_o, 1);
      if (md == 2'b11 && prev_fire) chk(!unit_req_o, "R8 gap after unit", unit_req_o, 0);
      if (md == 2'b10 && prev_req && !prev_fire) chk(unit_req_o, "R7 request held", unit_req_o, 1);
      unit_ack_i = 1'($urandom_range(0, 1));
      prev_req  = unit_req_o;
      prev_fire = unit_req_o && (md == 2'b01 || unit_ack_i);
      if (prev_fire) units++;
      @(negedge clk_i);
      iters++;
    end
    unit_ack_i = 1'b0;
    chk(seen_done && units == int'(cnt), "R5 unit count", units, cnt);
    chk(!active_o, "R5 idle after done", active_o, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk_i);
    chk(req_ready_o && !active_o && !unit_req_o && !done_o && !err_o && ch_req_o == 0,
        "R12 reset state", {req_ready_o, active_o, unit_req_o, done_o, err_o, ch_req_o}, 8'h80);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed transfers per mode
    run_xfer(2'b01, 8'd1, 3'b011, 1'b0, 32'h1000_0000);
    run_xfer(2'b01, 8'd7, 3'b100, 1'b1, 32'hDEAD_BEE0);
    run_xfer(2'b10, 8'd5, 3'b011, 1'b1, 32'h0000_0040);
    run_xfer(2'b11, 8'd6, 3'b100, 1'b0, 32'hFFFF_FFE0);
    run_xfer(2'b11, 8'd255, 3'b011, 1'b1, 32'h1234_5678);

    // R3: illegal size on channel 0
    put(mk(3'b101, 1'b0, 2'd0, 2'b01, 8'd3, 32'h0));
    chk(err_o && !active_o, "R3 illegal size", {err_o, active_o}, 2'b10);
    // R2: channel 1 with illegal size only strobes
    put(mk(3'b101, 1'b1, 2'd1, 2'b01, 8'd3, 32'h0));
    chk(ch_req_o == 3'b001 && !err_o && !active_o, "R2 chan1 strobe", {ch_req_o, err_o, active_o}, 5'b00100);
    @(negedge clk_i);
    chk(ch_req_o == 3'b000, "R2 strobe one cycle", ch_req_o, 0);
    put(mk(3'b011, 1'b0, 2'd2, 2'b11, 8'd9, 32'h0));
    chk(ch_req_o == 3'b010 && !active_o, "R2 chan2 strobe", ch_req_o, 3'b010);
    put(mk(3'b110, 1'b0, 2'd3, 2'b00, 8'd0, 32'h0));
    chk(ch_req_o == 3'b100 && !active_o, "R2 chan3 strobe", ch_req_o, 3'b100);

    // R4: handshake mode starts nothing
    put(mk(3'b011, 1'b0, 2'd0, 2'b00, 8'd4, 32'h0));
    repeat (3) begin
      chk(!active_o && !unit_req_o && !done_o, "R4 mode 00 ignored", {active_o, unit_req_o, done_o}, 0);
      @(negedge clk_i);
    end

    // R9: end while idle has no effect
    put(mk(3'b111, 1'b0, 2'd0, 2'b01, 8'd0, 32'h0));
    chk(!done_o && !active_o, "R9 end while idle", {done_o, active_o}, 0);

    // R11 and R10: held off words, then queue clear with pending unit
    unit_ack_i = 1'b0;
    put(mk(3'b011, 1'b0, 2'd0, 2'b10, 8'd10, 32'hA0));
    chk(active_o && unit_req_o, "R7 pending unit", {active_o, unit_req_o}, 2'b11);
    req_valid_i = 1'b1;
    req_word_i  = mk(3'b011, 1'b1, 2'd0, 2'b01, 8'd2, 32'hB0);
    #1 chk(!req_ready_o, "R11 start held off", req_ready_o, 0);
    @(negedge clk_i);
    req_word_i = mk(3'b011, 1'b1, 2'd1, 2'b01, 8'd2, 32'hB0);
    #1 chk(!req_ready_o, "R11 chan word held off", req_ready_o, 0);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(ch_req_o == 0 && unit_addr_o == 32'hA0 && active_o, "R11 no effect of held word",
        {ch_req_o, active_o, unit_addr_o}, {3'b0, 1'b1, 32'hA0});
    req_word_i = mk(3'b110, 1'b0, 2'd0, 2'b01, 8'd1, 32'h0);
    #1 chk(req_ready_o, "R11 command accepted", req_ready_o, 1);
    put(req_word_i);
    chk(!active_o && !done_o && !unit_req_o, "R10 queue clear", {active_o, done_o, unit_req_o}, 0);
    @(negedge clk_i);
    chk(!done_o && req_ready_o, "R10 no done", {done_o, req_ready_o}, 2'b01);

    // R5 zero count runs past 255, then R9 end
    put(mk(3'b011, 1'b0, 2'd0, 2'b01, 8'd0, 32'h44));
    repeat (300) @(negedge clk_i);
    chk(active_o && !done_o, "R5 zero count is maximum", {active_o, done_o}, 2'b10);
    put(mk(3'b111, 1'b0, 2'd0, 2'b00, 8'd0, 32'h0));
    chk(done_o && !active_o, "R9 end stops transfer", {done_o, active_o}, 2'b10);
    @(negedge clk_i);
    chk(!done_o, "R9 done single pulse", done_o, 0);

    // constrained random
    for (int i = 0; i < 25; i++) begin
      logic [1:0] ch = 2'($urandom_range(1, 3));
      run_xfer(2'($urandom_range(1, 3)), 8'($urandom_range(1, 40)), 3'($urandom_range(0, 4)),
               1'($urandom), $urandom);
      put(mk(3'($urandom), 1'($urandom), ch, 2'($urandom), 8'($urandom), $urandom));
      chk(ch_req_o == (3'b001 << (ch - 1)) && !err_o && !active_o, "R2 random strobe",
          ch_req_o, 3'b001 << (ch - 1));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule